// File: doc/BRIEF.md
# Packed GF(2^8) Doubling and Row-Combine Unit

This unit serves a cipher datapath that keeps four field elements of GF(2^8) packed in each 32-bit word. It offers two operations selected by an opcode. The doubling operation multiplies every byte of the first source word by x at once. The reduction term is taken from an 8-bit remainder input rather than fixed, so any degree-8 field polynomial x^8 + r(x) can be used. For the common cipher field x^8 + x^4 + x^3 + x + 1 the remainder input is 0x1B.

The row-combine operation folds selected bytes of both source words into a single byte by exclusive-or. An 8-bit selection mask lets each byte take part in the sum or not. This is the inner step of a matrix-by-vector product over the field, such as column mixing.

Both results are captured in output registers on the clock edge that follows a valid opcode. Any other opcode leaves both registers as they are.

Top module: `gf8_pack_helper`

## Requirements
- R1: While rst_n is low at a rising clock edge, word_o and byte_o are cleared to zero.
- R2: With op_i = 2'b01 (double), after the next rising edge each byte i of word_o (bits 8i+7..8i) equals that byte of word_a_i shifted left by one, truncated to 8 bits, then XORed with poly_rem_i if bit 7 of the source byte was set.
- R3: With poly_rem_i = 0x00 the doubling is a plain left shift inside each byte: the top bit of one byte never reaches bit 0 of the next byte, so bit 0 of every result byte is 0.
- R4: The doubling is correct for any remainder value, including the fields with remainders 0x1B, 0x1D and 0x4D.
- R5: With op_i = 2'b10 (row combine), after the next rising edge byte_o equals the XOR over k = 0..3 of (sel_mask_i[k] ? byte k of word_b_i : 0) and (sel_mask_i[k+4] ? byte k of word_a_i : 0).
- R6: A row combine with sel_mask_i = 0x00 gives byte_o = 0x00.
- R7: A double operation leaves byte_o unchanged, and a row combine leaves word_o unchanged.
- R8: Opcodes 2'b00 and 2'b11 leave word_o and byte_o unchanged.
- R9: A result appears at the outputs exactly one rising edge after the opcode and operands are presented, and no sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Operation: 01 double, 10 row combine, 00/11 hold |
| word_a_i | input | 32 | First packed source word |
| word_b_i | input | 32 | Second packed source word (row combine only) |
| poly_rem_i | input | 8 | Low 8 coefficients r(x) of the field polynomial |
| sel_mask_i | input | 8 | Byte selection mask for row combine |
| word_o | output | 32 | Registered doubling result |
| byte_o | output | 8 | Registered row-combine result |

## Verification
The assertions assume that op_i, the source words, the remainder and the mask are stable and known around each rising edge, and that reset stays low for at least one edge before the first operation. The bench drives every input on the falling edge and holds it for a full cycle. It asserts reset before any operation is issued. Opcodes are drawn only from the two-bit space, so every value, including the two hold codes, counts as a defined operation. The remainder and the mask are swept across zero, the all-ones value and several field polynomials, so the properties about a zero remainder and a zero mask are exercised alongside the general case.

// File: rtl/gf8_helper_pkg.sv
// Package: shared sizes and opcode encoding for the packed GF(2^8) helper.
// Assumes: bytes are 8 bits wide and a word holds LANES_DEF bytes.
package gf8_helper_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LANES_DEF = 4;

    // Opcode encoding seen on op_i.
    typedef enum logic [1:0] {
        OP_HOLD0  = 2'b00,
        OP_DOUBLE = 2'b01,
        OP_ROW    = 2'b10,
        OP_HOLD3  = 2'b11
    } gf8_op_e;

endpackage

// File: rtl/gf8_xtime_lane.sv
// Module: one byte lane of the doubling operation.
// Computes (in << 1) XOR (in[MSB] ? rem : 0), truncated to the lane width.
// Assumes: rem holds the low coefficients of the field polynomial.
module gf8_xtime_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lane_i,
    input  logic [W-1:0] rem_i,
    output logic [W-1:0] lane_o
);

    logic         carry_out;
    logic [W-1:0] shifted;
    logic [W-1:0] reduce;

    // Split the lane into the bit that leaves and the shifted remainder.
    always_comb begin
        carry_out = lane_i[W-1];
        shifted   = {lane_i[W-2:0], 1'b0};
    end

    // Fold the polynomial remainder back in when a bit overflowed.
    always_comb begin
        reduce = carry_out ? rem_i : '0;
        lane_o = shifted ^ reduce;
    end

endmodule

// File: rtl/gf8_xtime_word.sv
// Module: doubling of every byte of a packed word in parallel.
// One gf8_xtime_lane per byte; no bit moves between lanes.
// Assumes: the word width is LANES * W.
module gf8_xtime_word #(
    parameter int unsigned W     = 8,
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = W * LANES
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [W-1:0]      rem_i,
    output logic [WORD_W-1:0] word_o
);

    // Replicate a lane per byte position.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        gf8_xtime_lane #(.W(W)) u_lane (
            .lane_i (word_i[g*W +: W]),
            .rem_i  (rem_i),
            .lane_o (word_o[g*W +: W])
        );
    end

endmodule

// File: rtl/gf8_row_select.sv
// Module: gated XOR of the bytes of two packed words into one byte.
// Mask bit k gates byte k of word B; mask bit k+LANES gates byte k of word A.
// Assumes: the mask is 2*LANES bits wide.
module gf8_row_select #(
    parameter int unsigned W     = 8,
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = W * LANES,
    localparam int unsigned MASK_W = 2 * LANES
) (
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [W-1:0]      sum_o
);

    logic [W-1:0] term_a [LANES];
    logic [W-1:0] term_b [LANES];

    // Gate each byte of both words by its own mask bit.
    for (genvar g = 0; g < LANES; g++) begin : g_gate
        assign term_b[g] = mask_i[g]         ? word_b_i[g*W +: W] : '0;
        assign term_a[g] = mask_i[g + LANES] ? word_a_i[g*W +: W] : '0;
    end

    // Reduce all gated terms by exclusive-or.
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            sum_o = sum_o ^ term_a[k] ^ term_b[k];
        end
    end

endmodule

// File: rtl/gf8_pack_helper.sv
// Module: top of the packed GF(2^8) helper.
// Decodes the opcode, computes both operations combinationally and captures
// the selected result in its own output register one edge later.
// Assumes: synchronous active-low reset; op values 00 and 11 mean hold.
module gf8_pack_helper
    import gf8_helper_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    localparam int unsigned WORD_W = BYTE_W * LANES,
    localparam int unsigned MASK_W = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    input  logic [BYTE_W-1:0] poly_rem_i,
    input  logic [MASK_W-1:0] sel_mask_i,
    output logic [WORD_W-1:0] word_o,
    output logic [BYTE_W-1:0] byte_o
);

    logic              do_double;
    logic              do_row;
    logic [WORD_W-1:0] dbl_next;
    logic [BYTE_W-1:0] row_next;

    // Decode the opcode into one enable per result register.
    always_comb begin
        do_double = (op_i == OP_DOUBLE);
        do_row    = (op_i == OP_ROW);
    end

    gf8_xtime_word #(.W(BYTE_W), .LANES(LANES)) u_double (
        .word_i (word_a_i),
        .rem_i  (poly_rem_i),
        .word_o (dbl_next)
    );

    gf8_row_select #(.W(BYTE_W), .LANES(LANES)) u_row (
        .word_a_i (word_a_i),
        .word_b_i (word_b_i),
        .mask_i   (sel_mask_i),
        .sum_o    (row_next)
    );

    // Word result register: loads only on a double operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (do_double) begin
            word_o <= dbl_next;
        end
    end

    // Byte result register: loads only on a row combine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o <= '0;
        end else if (do_row) begin
            byte_o <= row_next;
        end
    end

    // R1: reset clears both result registers.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && byte_o == '0));

    // R3: with a zero remainder, bit 0 of every result byte is zero.
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r3_no_cross_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == OP_DOUBLE && poly_rem_i == '0) |=> (word_o[g*BYTE_W] == 1'b0));
    end

    // R6: an empty mask yields a zero byte.
    a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ROW && sel_mask_i == '0) |=> (byte_o == '0));

    // R7: each operation leaves the other result untouched.
    a_r7_row_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ROW) |=> $stable(word_o));
    a_r7_double_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DOUBLE) |=> $stable(byte_o));

    // R8: hold opcodes change nothing.
    a_r8_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD0 || op_i == OP_HOLD3) |=> ($stable(word_o) && $stable(byte_o)));

    // R2: doubling a zero word gives zero whatever the remainder.
    a_r2_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DOUBLE && word_a_i == '0) |=> (word_o == '0));

endmodule

// File: tb/tb_gf8_pack_helper.sv
module tb_gf8_pack_helper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_i;
    logic [31:0] word_a_i, word_b_i;
    logic [7:0]  poly_rem_i, sel_mask_i;
    logic [31:0] word_o;
    logic [7:0]  byte_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] word;
        logic [7:0]  byt;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_word;
    logic [7:0]  m_byte;

    always #5 clk = ~clk;

    gf8_pack_helper dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .word_a_i(word_a_i), .word_b_i(word_b_i),
        .poly_rem_i(poly_rem_i), .sel_mask_i(sel_mask_i),
        .word_o(word_o), .byte_o(byte_o)
    );

    // Field doubling as a polynomial product by x, reduced by x^8 + r(x).
    function automatic logic [7:0] ref_dbl(input logic [7:0] v, input logic [7:0] r);
        logic [8:0] p;
        p = {v, 1'b0};
        if (p[8]) p = p ^ {1'b1, r};
        return p[7:0];
    endfunction

    function automatic logic [7:0] ref_row(input logic [31:0] a, input logic [31:0] b,
                                           input logic [7:0] m);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < 4; k++) begin
            if (m[k])     s ^= b[8*k +: 8];
            if (m[k + 4]) s ^= a[8*k +: 8];
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one operation at the falling edge and queue its expectation.
    task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] rem, input logic [7:0] mask, input string tag);
        exp_t e;
        @(negedge clk);
        op_i = op; word_a_i = a; word_b_i = b; poly_rem_i = rem; sel_mask_i = mask;
        if (op == 2'b01) begin
            for (int i = 0; i < 4; i++) m_word[8*i +: 8] = ref_dbl(a[8*i +: 8], rem);
        end else if (op == 2'b10) begin
            m_byte = ref_row(a, b, mask);
        end
        e.word = m_word; e.byt = m_byte; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: shortly after each rising edge compare against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " word"}, word_o, e.word);
                check({e.tag, " byte"}, {24'h0, byte_o}, {24'h0, e.byt});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; op_i = 2'b01; word_a_i = 32'hFFFF_FFFF; word_b_i = 32'hFFFF_FFFF;
        poly_rem_i = 8'hFF; sel_mask_i = 8'hFF;
        m_word = '0; m_byte = '0;
        repeat (3) @(negedge clk);
        check("R1 reset word", word_o, 32'h0);
        check("R1 reset byte", {24'h0, byte_o}, 32'h0);
        op_i = 2'b00;
        rst_n = 1'b1;

        // R9: output must not change before the edge after the operation.
        @(negedge clk);
        op_i = 2'b01; word_a_i = 32'h0102_0304; poly_rem_i = 8'h1B;
        #1 check("R9 no early update", word_o, 32'h0);
        m_word = 32'h0204_0608;
        @(posedge clk); #2 check("R9 one edge latency", word_o, 32'h0204_0608);
        @(negedge clk); op_i = 2'b00;

        drive(2'b01, 32'h8057_AE01, 32'h0, 8'h1B, 8'h00, "R2 aes doubling");
        drive(2'b01, 32'hFFFF_FFFF, 32'h0, 8'h00, 8'h00, "R3 zero remainder");
        drive(2'b01, 32'h8080_8080, 32'h0, 8'h00, 8'h00, "R3 no carry between bytes");
        drive(2'b01, 32'h80C3_7FFE, 32'h0, 8'h1D, 8'h00, "R4 remainder 1D");
        drive(2'b01, 32'hF00F_8181, 32'h0, 8'h4D, 8'h00, "R4 remainder 4D");
        drive(2'b10, 32'h1122_3344, 32'h5566_7788, 8'h1B, 8'hFF, "R5 full mask");
        drive(2'b10, 32'h1122_3344, 32'h5566_7788, 8'h1B, 8'h11, "R5 lane0 both");
        drive(2'b10, 32'hA0B0_C0D0, 32'h0102_0408, 8'h1B, 8'h80, "R5 top byte of a");
        drive(2'b10, 32'hA0B0_C0D0, 32'h0102_0408, 8'h1B, 8'h08, "R5 top byte of b");
        drive(2'b10, 32'hDEAD_BEEF, 32'hCAFE_F00D, 8'h1B, 8'h00, "R6 empty mask");
        drive(2'b01, 32'h1234_5678, 32'h0, 8'h1B, 8'hFF, "R7 double keeps byte");
        drive(2'b10, 32'h9999_9999, 32'h7777_7777, 8'h1B, 8'h5A, "R7 row keeps word");
        drive(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 8'hFF, "R8 hold code 00");
        drive(2'b11, 32'h8888_8888, 32'h4444_4444, 8'h1B, 8'hF0, "R8 hold code 11");
        for (int n = 0; n < 200; n++) begin
            drive(2'($urandom), $urandom, $urandom, 8'($urandom), 8'($urandom),
                  "R2 R5 R8 mixed");
        end
        drive(2'b00, 32'h0, 32'h0, 8'h0, 8'h0, "R8 final hold");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule